// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line that rests high between frames. A frame opens with a falling edge into a low start bit. The data bits follow, least significant first. An optional parity bit may come next, and the frame closes with one or two high stop bits. The line passes through a flop synchronizer. After that, all timing is counted in pulses of an oversample tick enable. The tick runs at either 16 or 8 times the bit rate, and a configuration input selects which. The receiver waits one half bit from the edge to confirm the start bit. It then samples every bit at its centre: on the 8th tick in 16x mode and on the 4th tick in 8x mode.

Each received character is stored in a 16-entry first-in first-out buffer. The character is stored together with its own framing and parity error flags, so software reads the data and its status together while later frames are still arriving. The buffer is show-ahead: the oldest entry is always visible at the read port, and a read strobe discards it. A character that arrives when the buffer is full is lost, and a sticky overrun flag records the loss. The configuration inputs set the data width, the parity enable, the parity sense and the stop length. They must only change while the line is idle.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset the buffer is empty (`rd_empty`=1, `rd_level`=0) and `overrun` is 0.
- R2: With `cfg_os8`=0, a falling edge on the idle line starts a frame. The start bit and each later bit are sampled at the 8th tick of the bit. Data is assembled least significant bit first, and an 8-bit frame stores the byte exactly as sent.
- R3: With `cfg_os8`=1, the same frame is received correctly when the ticks run at 8 per bit, with each bit sampled on its 4th tick.
- R4: With `cfg_data7`=1, only 7 data bits are taken from the line and bit 7 of the stored byte is 0.
- R5: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the data bits and the parity bit must hold an even number of ones; with `cfg_par_odd`=1 an odd number. A mismatch sets `rd_parity_err` for that byte only.
- R6: A low level at any stop-bit sample sets `rd_frame_err` for that byte. With `cfg_stop2`=1 both stop bits are sampled. The byte is still stored.
- R7: If the line is high again at the start-bit centre sample, the frame is abandoned and nothing is stored.
- R8: Stored bytes come out in arrival order. `rd_level` counts them, and a pulse on `rd_en` while the buffer is not empty removes the head entry.
- R9: A byte that completes while 16 entries are held is discarded, the held entries are unchanged, and `overrun` goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idles high |
| os_tick | input | 1 | Oversample enable, 16 or 8 pulses per bit time |
| cfg_os8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_data7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_en | input | 1 | Removes the head entry when the buffer is not empty |
| rd_data | output | 8 | Data byte of the head entry |
| rd_frame_err | output | 1 | Framing error flag of the head entry |
| rd_parity_err | output | 1 | Parity error flag of the head entry |
| rd_empty | output | 1 | Buffer holds no entries |
| rd_level | output | 5 | Number of entries held |
| overrun | output | 1 | Sticky flag: a byte was lost to a full buffer |

## Verification
The bytes 0xA5, 0x00, 0xFF and 0x3C are sent in both oversampling modes. The alternating bits of 0xA5 and 0x3C show whether bit order and centre sampling are right. The all-zero and all-one bytes show whether the start and stop bits are kept apart from the data. Frames with correct and deliberately wrong parity bits under both parity senses show that the flag follows the parity rule. Corrupted first and second stop bits show that each stop sample is checked. A short low pulse in front of a valid frame shows that a glitch is rejected without losing the frame that follows. A burst of 17 frames with no reads separates correct storage of the first 16 from loss of the 17th, and shows that the overrun flag stays set afterwards.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic       perr;
      logic       ferr;
      logic [7:0] data;
   } rx_item_t;

   localparam int unsigned ITEM_W = $bits(rx_item_t);

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RESET_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_s,
   input  logic       os_tick,
   input  logic       cfg_os8,
   input  logic       cfg_data7,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_stop2,
   output logic       push_o,
   output rx_item_t   push_item
);

   localparam int unsigned CNT_W = 4;

   rx_state_t         st;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bitn;
   logic [7:0]        shreg;
   logic              par_acc;
   logic              ferr_q;
   logic              perr_q;
   logic              stopn;
   logic              line_q;

   logic [CNT_W-1:0]  half_last;
   logic [CNT_W-1:0]  full_last;
   logic [2:0]        data_last;
   logic              centre;
   logic              at_bit_end;
   logic              fe_now;

   always_comb begin
      half_last  = cfg_os8 ? CNT_W'(3) : CNT_W'(7);
      full_last  = cfg_os8 ? CNT_W'(7) : CNT_W'(15);
      data_last  = cfg_data7 ? 3'd6 : 3'd7;
      centre     = (st == RX_START) ? (cnt == half_last) : (cnt == full_last);
      at_bit_end = os_tick && (st != RX_IDLE) && centre;
      fe_now     = ferr_q | ~rx_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         ferr_q    <= 1'b0;
         perr_q    <= 1'b0;
         stopn     <= 1'b0;
         line_q    <= 1'b1;
         push_o    <= 1'b0;
         push_item <= '0;
      end else begin
         push_o <= 1'b0;
         if (os_tick) begin
            line_q <= rx_s;
            if (st == RX_IDLE) begin
               if (line_q && !rx_s) begin
                  st  <= RX_START;
                  cnt <= CNT_W'(1);
               end
            end else if (!at_bit_end) begin
               cnt <= cnt + CNT_W'(1);
            end else begin
               cnt <= '0;
               unique case (st)
                  RX_START: begin
                     if (rx_s) begin
                        st <= RX_IDLE;
                     end else begin
                        st      <= RX_DATA;
                        bitn    <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        ferr_q  <= 1'b0;
                        perr_q  <= 1'b0;
                        stopn   <= 1'b0;
                     end
                  end
                  RX_DATA: begin
                     shreg[bitn] <= rx_s;
                     par_acc     <= par_acc ^ rx_s;
                     if (bitn == data_last) begin
                        st <= cfg_par_en ? RX_PARITY : RX_STOP;
                     end else begin
                        bitn <= bitn + 3'd1;
                     end
                  end
                  RX_PARITY: begin
                     perr_q <= par_acc ^ rx_s ^ cfg_par_odd;
                     st     <= RX_STOP;
                  end
                  RX_STOP: begin
                     if (cfg_stop2 && !stopn) begin
                        ferr_q <= fe_now;
                        stopn  <= 1'b1;
                     end else begin
                        push_o         <= 1'b1;
                        push_item.data <= shreg;
                        push_item.ferr <= fe_now;
                        push_item.perr <= perr_q;
                        st             <= RX_IDLE;
                     end
                  end
                  default: st <= RX_IDLE;
               endcase
            end
         end
      end
   end

   // R2
   push_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> $past(os_tick));

   // R4
   bit7_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && cfg_data7) |-> !push_item.data[7]);

   // R7
   glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_START && os_tick && cnt == half_last && rx_s)
         |=> (st == RX_IDLE && !push_o));

   // R6
   stop_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_o) |-> $past(st == RX_STOP));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WIDTH = 10,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic [LW-1:0]    level,
   output logic             ovf
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("srx_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("srx_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp;
   logic [AW-1:0]    rp;
   logic [LW-1:0]    count;
   logic             full;
   logic             wr_ok;
   logic             rd_ok;

   always_comb begin
      full  = (count == LW'(DEPTH));
      empty = (count == '0);
      wr_ok = push && !full;
      rd_ok = pop && !empty;
      rdata = mem[rp];
      level = count;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (wr_ok) wp <= wp + AW'(1);
         if (rd_ok) rp <= rp + AW'(1);
         unique case ({wr_ok, rd_ok})
            2'b10:   count <= count + LW'(1);
            2'b01:   count <= count - LW'(1);
            default: count <= count;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == LW'(DEPTH)));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);

   // R8
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LW'(DEPTH));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
   import srx_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LVL_W      = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic             os_tick,
   input  logic             cfg_os8,
   input  logic             cfg_data7,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   input  logic             cfg_stop2,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_frame_err,
   output logic             rd_parity_err,
   output logic             rd_empty,
   output logic [LVL_W-1:0] rd_level,
   output logic             overrun
);

   logic     rx_s;
   logic     push;
   rx_item_t push_item;
   rx_item_t head;

   srx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_line),
      .d_out (rx_s)
   );

   srx_frame i_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_s        (rx_s),
      .os_tick     (os_tick),
      .cfg_os8     (cfg_os8),
      .cfg_data7   (cfg_data7),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .cfg_stop2   (cfg_stop2),
      .push_o      (push),
      .push_item   (push_item)
   );

   srx_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (ITEM_W)
   ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (push_item),
      .pop   (rd_en),
      .rdata (head),
      .empty (rd_empty),
      .level (rd_level),
      .ovf   (overrun)
   );

   assign rd_data       = head.data;
   assign rd_frame_err  = head.ferr;
   assign rd_parity_err = head.perr;

   // R1
   empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty == (rd_level == '0));

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;

   localparam int TDIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic       cfg_os8 = 1'b0;
   logic       cfg_data7 = 1'b0;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_stop2 = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_frame_err;
   logic       rd_parity_err;
   logic       rd_empty;
   logic [4:0] rd_level;
   logic       overrun;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   mon_en  = 1'b0;
   bit   done    = 1'b0;

   logic [9:0] exp_q[$];
   string      tag_q[$];

   serial_frame_rx i_serial_frame_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_line       (rx_line),
      .os_tick       (os_tick),
      .cfg_os8       (cfg_os8),
      .cfg_data7     (cfg_data7),
      .cfg_par_en    (cfg_par_en),
      .cfg_par_odd   (cfg_par_odd),
      .cfg_stop2     (cfg_stop2),
      .rd_en         (rd_en),
      .rd_data       (rd_data),
      .rd_frame_err  (rd_frame_err),
      .rd_parity_err (rd_parity_err),
      .rd_empty      (rd_empty),
      .rd_level      (rd_level),
      .overrun       (overrun)
   );

   always #2 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         os_tick = 1'b1;
         @(negedge clk);
         os_tick = 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: pops the head when the buffer holds data
   initial begin
      forever begin
         @(negedge clk);
         rd_en = 1'b0;
         if (mon_en && !rd_empty) begin
            n_tests++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R8 unexpected entry actual=%0h expected=none",
                        {rd_parity_err, rd_frame_err, rd_data});
            end else begin
               logic [9:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if ({rd_parity_err, rd_frame_err, rd_data} != e) begin
                  n_fail++;
                  $display("FAIL %s actual=%0h expected=%0h", t,
                           {rd_parity_err, rd_frame_err, rd_data}, e);
               end
            end
            rd_en = 1'b1;
         end
      end
   end

   task automatic bit_time(input logic v);
      rx_line = v;
      repeat ((cfg_os8 ? 8 : 16) * TDIV) @(negedge clk);
   endtask

   // Driver: sends one frame and records the expected entry
   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_s1,
                       input bit bad_s2, input bit store, input string tag);
      int         nb;
      logic       p;
      logic [7:0] ed;
      nb = cfg_data7 ? 7 : 8;
      ed = cfg_data7 ? {1'b0, d[6:0]} : d;
      p  = (^ed) ^ cfg_par_odd ^ bad_par;
      if (store) begin
         exp_q.push_back({cfg_par_en & bad_par, bad_s1 | (cfg_stop2 & bad_s2), ed});
         tag_q.push_back(tag);
      end
      bit_time(1'b0);
      for (int i = 0; i < nb; i++) bit_time(d[i]);
      if (cfg_par_en) bit_time(p);
      bit_time(!bad_s1);
      if (cfg_stop2) bit_time(!bad_s2);
      if (bad_s1 || bad_s2) bit_time(1'b1);
   endtask

   task automatic idle(input int bits);
      for (int i = 0; i < bits; i++) bit_time(1'b1);
   endtask

   task automatic drain;
      int w;
      w = 0;
      while ((exp_q.size() != 0 || !rd_empty) && w < 4000) begin
         @(negedge clk);
         w++;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 empty", int'(rd_empty), 1);
      chk("R1 level", int'(rd_level), 0);
      chk("R1 overrun", int'(overrun), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_en = 1'b1;

      // R2 16x oversampling, 8 data bits
      send(8'hA5, 0, 0, 0, 1, "R2 A5");
      send(8'h00, 0, 0, 0, 1, "R2 00");
      send(8'hFF, 0, 0, 0, 1, "R2 FF");
      send(8'h3C, 0, 0, 0, 1, "R2 3C");
      idle(2);
      drain();

      // R3 8x oversampling
      cfg_os8 = 1'b1;
      send(8'hA5, 0, 0, 0, 1, "R3 A5");
      send(8'h00, 0, 0, 0, 1, "R3 00");
      send(8'hFF, 0, 0, 0, 1, "R3 FF");
      send(8'h3C, 0, 0, 0, 1, "R3 3C");
      idle(2);
      drain();
      cfg_os8 = 1'b0;

      // R4 7-bit data
      cfg_data7 = 1'b1;
      send(8'hD3, 0, 0, 0, 1, "R4 53");
      send(8'h7F, 0, 0, 0, 1, "R4 7F");
      idle(2);
      drain();

      // R5 parity, even then odd, good and bad
      cfg_par_en = 1'b1;
      send(8'h35, 0, 0, 0, 1, "R5 even7 ok");
      cfg_data7 = 1'b0;
      send(8'h96, 0, 0, 0, 1, "R5 even ok");
      send(8'h96, 1, 0, 0, 1, "R5 even bad");
      cfg_par_odd = 1'b1;
      send(8'h01, 0, 0, 0, 1, "R5 odd ok");
      send(8'h01, 1, 0, 0, 1, "R5 odd bad");
      idle(2);
      drain();
      cfg_par_en  = 1'b0;
      cfg_par_odd = 1'b0;

      // R6 framing errors on either stop sample
      send(8'h5A, 0, 1, 0, 1, "R6 stop low");
      cfg_stop2 = 1'b1;
      send(8'hC3, 0, 0, 0, 1, "R6 two stops ok");
      send(8'hC3, 0, 0, 1, 1, "R6 second stop low");
      send(8'h24, 0, 1, 0, 1, "R6 first stop low");
      idle(2);
      drain();
      cfg_stop2 = 1'b0;

      // R7 short low pulse before a valid frame
      rx_line = 1'b0;
      repeat (3 * TDIV) @(negedge clk);
      rx_line = 1'b1;
      idle(2);
      chk("R7 glitch stored nothing", int'(rd_empty), 1);
      send(8'h81, 0, 0, 0, 1, "R7 after glitch");
      idle(2);
      drain();

      // R8 ordered storage without reads
      mon_en = 1'b0;
      for (int i = 0; i < 5; i++) send(8'(8'h10 + i), 0, 0, 0, 1, "R8 order");
      idle(2);
      chk("R8 level", int'(rd_level), 5);
      chk("R8 no overrun", int'(overrun), 0);
      mon_en = 1'b1;
      drain();
      chk("R8 level drained", int'(rd_level), 0);

      // R9 overflow: 17th byte discarded
      mon_en = 1'b0;
      for (int i = 0; i < 17; i++)
         send(8'(8'h40 + i), 0, 0, 0, i < 16, "R9 kept");
      idle(2);
      chk("R9 level full", int'(rd_level), 16);
      chk("R9 overrun set", int'(overrun), 1);
      mon_en = 1'b1;
      drain();
      chk("R9 overrun sticky", int'(overrun), 1);
      chk("R9 empty after drain", int'(rd_empty), 1);
      chk("R8 all expected seen", exp_q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule